// File: doc/BRIEF.md
# Overlapping Register Window File

This block is a processor register file in which most of the register space is divided into windows that overlap. There are eight global registers and four windows. Each window has four incoming-argument registers, four private registers and four outgoing-argument registers. The windows are arranged in a ring. The outgoing-argument registers of one window are the same physical storage as the incoming-argument registers of the window that follows it. A caller therefore places arguments in its outgoing registers, and after a call the callee finds them in its incoming registers, with no data moved.

Software addresses registers by logical number. A current window pointer maps each logical number onto physical storage. The call strobe moves the pointer forward one window and the return strobe moves it back one window. A saved window pointer, internal to the block, marks the window that will be restored next from memory.

- A call that would move the pointer onto the saved window raises an overflow trap.
- A return that would move the pointer onto the saved window raises an underflow trap.

While a trap is pending, the pointer move is held. It completes when the spill or fill acknowledge arrives, and at that point the saved pointer also steps. The memory traffic itself is outside this block.

Top module: `register_window_file`

## Requirements
- R1: After reset the window pointer is 0, both traps are low, the saved window pointer is 3, and every register reads 0.
- R2: Logical registers 0 to 7 are globals. They map to the same storage in every window.
- R3: With no trap pending, a single-cycle call (return) with no trap condition changes the window pointer to (pointer+1) mod 4 (or (pointer-1) mod 4) at the next clock edge.
- R4: Logical registers 16 to 19 (outgoing area, index t = number-16) of window k are the same storage as logical registers 8 to 11 (incoming area, index t = number-8) of window (k+1) mod 4. This includes the wrap from window 3 to window 0.
- R5: Logical registers 12 to 15 are private to each window. A write to them in one window is not visible from any other window.
- R6: A call when (pointer+1) mod 4 equals the saved pointer raises the overflow trap at the next edge. The pointer is then held until the spill acknowledge is seen high. At that edge the pointer advances by one, the saved pointer advances by one, and the trap clears.
- R7: A return when (pointer-1) mod 4 equals the saved pointer raises the underflow trap at the next edge. The pointer is then held until the fill acknowledge is seen high. At that edge the pointer retreats by one, the saved pointer retreats by one, and the trap clears.
- R8: The pointer never equals the saved pointer. From reset, the first return underflows, and the third consecutive call overflows.
- R9: The following inputs have no effect on the pointer or the traps:
  - call and return strobes while a trap is pending;
  - call and return asserted in the same cycle;
  - an acknowledge seen while no trap is pending.
- R10: Writes are discarded while either trap is pending. Logical numbers 20 to 31 read as 0, and writes to them are discarded.
- R11: Both read ports are combinational and independent. A write takes effect at the clock edge, so a read of the same register in the write cycle returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| callReq | input | 1 | Call strobe, one cycle per call |
| retReq | input | 1 | Return strobe, one cycle per return |
| rdAddrA | input | 5 | Logical register number, read port A |
| rdDataA | output | 32 | Read data, port A |
| rdAddrB | input | 5 | Logical register number, read port B |
| rdDataB | output | 32 | Read data, port B |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 5 | Logical register number for the write |
| wrData | input | 32 | Write data |
| spillAck | input | 1 | Oldest window has been saved to memory |
| fillAck | input | 1 | Window has been restored from memory |
| ovfTrap | output | 1 | Overflow trap, held until spillAck |
| unfTrap | output | 1 | Underflow trap, held until fillAck |
| cwp | output | 2 | Current window pointer |

## Verification
The assertions assume the following about the inputs:
- The call and return strobes are sampled every cycle, so a strobe held high acts as a series of calls or returns.
- An acknowledge is meaningful only while its own trap is high.
- Every input changes away from the rising edge.

The stimulus drives all inputs on the falling edge and holds each strobe for exactly one cycle. It raises acknowledges both while a trap is pending and, deliberately, while none is pending, so that the "ignored" cases of R9 are exercised without breaking those assumptions.

// File: rtl/rwf_pkg.sv
package rwf_pkg;
  parameter int DATA_W   = 32;
  parameter int GLOBAL_N = 8;
  parameter int AREA_N   = 4;
  parameter int WIN_N    = 4;

  localparam int WIN_W   = (WIN_N > 1) ? $clog2(WIN_N) : 1;
  localparam int LOGIC_N = GLOBAL_N + 3 * AREA_N;
  localparam int ADDR_W  = $clog2(LOGIC_N);
  localparam int GIDX_W  = (GLOBAL_N > 1) ? $clog2(GLOBAL_N) : 1;
  localparam int AIDX_W  = (AREA_N > 1) ? $clog2(AREA_N) : 1;

  typedef logic [WIN_W-1:0] winPtr_t;

  typedef enum logic [2:0] {
    REG_GLOBAL, REG_PARAM, REG_LOCAL, REG_TEMP, REG_NONE
  } regArea_t;

  typedef enum logic [1:0] {ST_RUN, ST_SPILL, ST_FILL} winState_t;

  // Strobes from control to datapath
  typedef struct packed {
    winPtr_t curWin;
    logic    wrGate;
  } ctrlStrobe_t;

  function automatic winPtr_t winNext(winPtr_t p);
    return (int'(p) == WIN_N - 1) ? winPtr_t'(0) : winPtr_t'(int'(p) + 1);
  endfunction

  function automatic winPtr_t winPrev(winPtr_t p);
    return (int'(p) == 0) ? winPtr_t'(WIN_N - 1) : winPtr_t'(int'(p) - 1);
  endfunction

  function automatic regArea_t areaOf(logic [ADDR_W-1:0] a);
    int v;
    v = int'(a);
    if (v < GLOBAL_N)                   return REG_GLOBAL;
    else if (v < GLOBAL_N + AREA_N)     return REG_PARAM;
    else if (v < GLOBAL_N + 2 * AREA_N) return REG_LOCAL;
    else if (v < LOGIC_N)               return REG_TEMP;
    else                                return REG_NONE;
  endfunction

  function automatic int areaBase(regArea_t r);
    case (r)
      REG_PARAM: return GLOBAL_N;
      REG_LOCAL: return GLOBAL_N + AREA_N;
      REG_TEMP:  return GLOBAL_N + 2 * AREA_N;
      default:   return 0;
    endcase
  endfunction
endpackage

// File: rtl/rwf_ctrl.sv
module rwf_ctrl
  import rwf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        callReq,
  input  logic        retReq,
  input  logic        spillAck,
  input  logic        fillAck,
  output logic        ovfTrap,
  output logic        unfTrap,
  output ctrlStrobe_t strobe
);
  winState_t state;
  winPtr_t   curWin;
  winPtr_t   savedWin;
  logic      callOnly;
  logic      retOnly;

  assign callOnly = callReq && !retReq;
  assign retOnly  = retReq && !callReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_RUN;
      curWin   <= '0;
      savedWin <= winPtr_t'(WIN_N - 1);
    end else begin
      case (state)
        ST_RUN: begin
          if (callOnly) begin
            if (winNext(curWin) == savedWin) state  <= ST_SPILL;
            else                             curWin <= winNext(curWin);
          end else if (retOnly) begin
            if (winPrev(curWin) == savedWin) state  <= ST_FILL;
            else                             curWin <= winPrev(curWin);
          end
        end
        ST_SPILL: begin
          if (spillAck) begin
            savedWin <= winNext(savedWin);
            curWin   <= winNext(curWin);
            state    <= ST_RUN;
          end
        end
        ST_FILL: begin
          if (fillAck) begin
            savedWin <= winPrev(savedWin);
            curWin   <= winPrev(curWin);
            state    <= ST_RUN;
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  assign ovfTrap       = (state == ST_SPILL);
  assign unfTrap       = (state == ST_FILL);
  assign strobe.curWin = curWin;
  assign strobe.wrGate = (state == ST_RUN);

  // R8: pointers never coincide
  assert_ptr_apart_R8: assert property (@(posedge clk) disable iff (!rstN)
    curWin != savedWin);

  // R6: pointer frozen while spill outstanding
  assert_spill_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ovfTrap && !spillAck) |=> ($stable(curWin) && ovfTrap));

  // R6: acknowledge completes the call
  assert_spill_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ovfTrap && spillAck) |=>
      (!ovfTrap && int'(curWin) == (int'($past(curWin)) + 1) % WIN_N));

  // R6: overflow only follows a lone call
  assert_ovf_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfTrap) |-> ($past(callReq) && !$past(retReq)));

  // R7: pointer frozen while fill outstanding
  assert_fill_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (unfTrap && !fillAck) |=> ($stable(curWin) && unfTrap));

  // R7: acknowledge completes the return
  assert_fill_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (unfTrap && fillAck) |=>
      (!unfTrap && int'(curWin) == (int'($past(curWin)) + WIN_N - 1) % WIN_N));

  // R9: simultaneous strobes do nothing
  assert_dual_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!ovfTrap && !unfTrap && callReq && retReq) |=>
      ($stable(curWin) && !ovfTrap && !unfTrap));
endmodule

// File: rtl/rwf_datapath.sv
module rwf_datapath
  import rwf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData
);
  localparam int RD_PORTS = 2;

  logic [DATA_W-1:0] globalReg [GLOBAL_N];
  // sharedReg[w] = incoming area of window w = outgoing area of window w-1
  logic [DATA_W-1:0] sharedReg [WIN_N][AREA_N];
  logic [DATA_W-1:0] localReg  [WIN_N][AREA_N];

  logic [ADDR_W-1:0] rdAddr [RD_PORTS];
  logic [DATA_W-1:0] rdData [RD_PORTS];
  winPtr_t           nextWin;

  assign rdAddr[0] = rdAddrA;
  assign rdAddr[1] = rdAddrB;
  assign rdDataA   = rdData[0];
  assign rdDataB   = rdData[1];
  assign nextWin   = winNext(strobe.curWin);

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_read
    regArea_t rdArea;
    int       rdOff;
    always_comb begin
      rdArea = areaOf(rdAddr[p]);
      rdOff  = int'(rdAddr[p]) - areaBase(rdArea);
      case (rdArea)
        REG_GLOBAL: rdData[p] = globalReg[GIDX_W'(rdOff)];
        REG_PARAM:  rdData[p] = sharedReg[strobe.curWin][AIDX_W'(rdOff)];
        REG_LOCAL:  rdData[p] = localReg[strobe.curWin][AIDX_W'(rdOff)];
        REG_TEMP:   rdData[p] = sharedReg[nextWin][AIDX_W'(rdOff)];
        default:    rdData[p] = '0;
      endcase
    end
  end

  regArea_t wrArea;
  int       wrOff;
  always_comb begin
    wrArea = areaOf(wrAddr);
    wrOff  = int'(wrAddr) - areaBase(wrArea);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int g = 0; g < GLOBAL_N; g++) globalReg[g] <= '0;
      for (int w = 0; w < WIN_N; w++) begin
        for (int i = 0; i < AREA_N; i++) begin
          sharedReg[w][i] <= '0;
          localReg[w][i]  <= '0;
        end
      end
    end else if (wrEn && strobe.wrGate) begin
      case (wrArea)
        REG_GLOBAL: globalReg[GIDX_W'(wrOff)] <= wrData;
        REG_PARAM:  sharedReg[strobe.curWin][AIDX_W'(wrOff)] <= wrData;
        REG_LOCAL:  localReg[strobe.curWin][AIDX_W'(wrOff)] <= wrData;
        REG_TEMP:   sharedReg[nextWin][AIDX_W'(wrOff)] <= wrData;
        default: ;
      endcase
    end
  end

  // R11: two ports on one register agree
  assert_ports_agree_R11: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddrA == rdAddrB) |-> (rdDataA == rdDataB));
endmodule

// File: rtl/register_window_file.sv
module register_window_file
  import rwf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              callReq,
  input  logic              retReq,
  input  logic [ADDR_W-1:0] rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              spillAck,
  input  logic              fillAck,
  output logic              ovfTrap,
  output logic              unfTrap,
  output logic [WIN_W-1:0]  cwp
);
  ctrlStrobe_t strobe;

  rwf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .callReq(callReq), .retReq(retReq),
    .spillAck(spillAck), .fillAck(fillAck),
    .ovfTrap(ovfTrap), .unfTrap(unfTrap), .strobe(strobe)
  );

  rwf_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB),
    .rdDataA(rdDataA), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData)
  );

  assign cwp = strobe.curWin;
endmodule

// File: tb/register_window_file_test.sv
module register_window_file_test;
  logic        clk = 0;
  logic        rstN = 0;
  logic        callReq = 0, retReq = 0, spillAck = 0, fillAck = 0, wrEn = 0;
  logic [4:0]  rdAddrA = 0, rdAddrB = 0, wrAddr = 0;
  logic [31:0] wrData = 0;
  logic [31:0] rdDataA, rdDataB;
  logic        ovfTrap, unfTrap;
  logic [1:0]  cwp;

  int compared = 0;
  int mismatched = 0;
  string phaseTag = "R1";

  register_window_file uut (
    .clk(clk), .rstN(rstN), .callReq(callReq), .retReq(retReq),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .spillAck(spillAck), .fillAck(fillAck),
    .ovfTrap(ovfTrap), .unfTrap(unfTrap), .cwp(cwp)
  );

  always #5 clk = ~clk;

  // Behavioural reference: logical view keyed per window
  int mCwp, mSwp;
  bit mOvf, mUnf;
  logic [31:0] mGlob [8];
  logic [31:0] mWin [int];

  function automatic int keyOf(int win, int a);
    if (a >= 8 && a < 12)  return win * 4 + (a - 8);
    if (a >= 16 && a < 20) return ((win + 1) % 4) * 4 + (a - 16);
    return 100 + win * 4 + (a - 12);
  endfunction

  function automatic logic [31:0] mRead(int a);
    if (a < 8) return mGlob[a];
    if (a >= 20) return 32'h0;
    if (mWin.exists(keyOf(mCwp, a))) return mWin[keyOf(mCwp, a)];
    return 32'h0;
  endfunction

  task automatic mReset();
    mCwp = 0; mSwp = 3; mOvf = 0; mUnf = 0;
    for (int i = 0; i < 8; i++) mGlob[i] = 0;
    mWin.delete();
  endtask

  always @(posedge clk) begin
    if (!rstN) mReset();
    else begin
      if (wrEn && !mOvf && !mUnf) begin
        if (wrAddr < 8) mGlob[wrAddr] = wrData;
        else if (wrAddr < 20) mWin[keyOf(mCwp, int'(wrAddr))] = wrData;
      end
      if (mOvf) begin
        if (spillAck) begin mSwp = (mSwp + 1) % 4; mCwp = (mCwp + 1) % 4; mOvf = 0; end
      end else if (mUnf) begin
        if (fillAck) begin mSwp = (mSwp + 3) % 4; mCwp = (mCwp + 3) % 4; mUnf = 0; end
      end else if (callReq && !retReq) begin
        if ((mCwp + 1) % 4 == mSwp) mOvf = 1; else mCwp = (mCwp + 1) % 4;
      end else if (retReq && !callReq) begin
        if ((mCwp + 3) % 4 == mSwp) mUnf = 1; else mCwp = (mCwp + 3) % 4;
      end
    end
  end

  task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", phaseTag, what, act, exp);
    end
  endtask

  task automatic compareAll();
    cmp("cwp", 32'(cwp), 32'(mCwp));
    cmp("ovfTrap", 32'(ovfTrap), 32'(mOvf));
    cmp("unfTrap", 32'(unfTrap), 32'(mUnf));
    cmp("rdDataA", rdDataA, mRead(int'(rdAddrA)));
    cmp("rdDataB", rdDataB, mRead(int'(rdAddrB)));
  endtask

  task automatic step(input bit c, input bit r, input bit sa, input bit fa,
                      input bit we, input int wa, input logic [31:0] wd,
                      input int ra, input int rb);
    @(negedge clk);
    callReq = c; retReq = r; spillAck = sa; fillAck = fa;
    wrEn = we; wrAddr = 5'(wa); wrData = wd; rdAddrA = 5'(ra); rdAddrB = 5'(rb);
    #1 compareAll();
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; callReq = 0; retReq = 0; spillAck = 0; fillAck = 0; wrEn = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog: actual hung expected finished");
    finishRun();
  end

  initial begin
    mReset();
    doReset();
    // R1: reset state, all registers zero
    phaseTag = "R1";
    step(0,0,0,0, 0,0,0, 0,19);
    cmp("R1 cwp at reset", 32'(cwp), 32'h0);
    step(0,0,0,0, 0,0,0, 12,8);
    // R2: global written in window 0 seen in window 1
    phaseTag = "R2";
    step(0,0,0,0, 1,3,32'hA1A1, 3,3);
    step(1,0,0,0, 0,0,0, 3,0);
    step(0,0,0,0, 0,0,0, 3,7);
    cmp("R2 global in window 1", rdDataA, 32'hA1A1);
    // R4: outgoing of window 1 becomes incoming of window 2; R3 pointer steps
    phaseTag = "R4";
    step(0,0,0,0, 1,18,32'hB2B2, 18,10);
    step(1,0,0,0, 0,0,0, 18,10);
    step(0,0,0,0, 0,0,0, 10,18);
    cmp("R4 incoming after call", rdDataA, 32'hB2B2);
    cmp("R3 pointer after call", 32'(cwp), 32'h2);
    // R5: locals private
    phaseTag = "R5";
    step(0,0,0,0, 1,12,32'hC3C3, 12,12);
    step(0,1,0,0, 0,0,0, 12,10);
    step(0,0,0,0, 0,0,0, 12,18);
    cmp("R5 local of window 1", rdDataA, 32'h0);
    cmp("R3 pointer after return", 32'(cwp), 32'h1);
    // R6: overflow at third resident window
    phaseTag = "R6";
    step(1,0,0,0, 0,0,0, 0,0);
    step(1,0,0,0, 0,0,0, 0,0);
    step(0,0,0,0, 0,0,0, 0,0);
    cmp("R6 overflow raised", 32'(ovfTrap), 32'h1);
    // R9: strobes while trap ignored; R10: write while trap ignored
    phaseTag = "R9";
    step(1,0,0,0, 0,0,0, 0,0);
    step(0,1,0,1, 0,0,0, 0,0);
    phaseTag = "R10";
    step(0,0,0,0, 1,4,32'hDEAD, 4,4);
    step(0,0,0,0, 0,0,0, 4,4);
    cmp("R10 write during trap", rdDataA, 32'h0);
    phaseTag = "R6";
    step(0,0,1,0, 0,0,0, 0,0);
    step(0,0,0,0, 0,0,0, 0,0);
    cmp("R6 pointer after spill", 32'(cwp), 32'h3);
    cmp("R6 trap cleared", 32'(ovfTrap), 32'h0);
    // R4 wrap: window 3 outgoing is window 0 incoming
    phaseTag = "R4";
    step(0,0,0,0, 1,16,32'hD4D4, 0,0);
    step(1,0,0,0, 0,0,0, 0,0);
    step(0,0,1,0, 0,0,0, 0,0);
    step(0,0,0,0, 0,0,0, 8,16);
    cmp("R4 wrap 3 to 0", rdDataA, 32'hD4D4);
    // R7: underflow
    phaseTag = "R7";
    step(0,1,0,0, 0,0,0, 0,0);
    step(0,1,0,0, 0,0,0, 0,0);
    step(0,1,0,0, 0,0,0, 0,0);
    step(0,0,0,0, 0,0,0, 0,0);
    cmp("R7 underflow raised", 32'(unfTrap), 32'h1);
    step(0,0,0,1, 0,0,0, 0,0);
    step(0,0,0,0, 0,0,0, 0,0);
    cmp("R7 pointer after fill", 32'(cwp), 32'h1);
    // R9: both strobes, stray acknowledges
    phaseTag = "R9";
    step(1,1,0,0, 0,0,0, 0,0);
    step(0,0,1,1, 0,0,0, 0,0);
    step(0,0,0,0, 0,0,0, 0,0);
    cmp("R9 pointer unchanged", 32'(cwp), 32'h1);
    // R10: unmapped numbers
    phaseTag = "R10";
    step(0,0,0,0, 1,25,32'h5555, 25,31);
    step(0,0,0,0, 0,0,0, 25,20);
    cmp("R10 unmapped read", rdDataA, 32'h0);
    // R11: old value in write cycle, new after edge
    phaseTag = "R11";
    step(0,0,0,0, 1,3,32'h7777, 3,12);
    cmp("R11 old value in write cycle", rdDataA, 32'hA1A1);
    step(0,0,0,0, 0,0,0, 3,12);
    cmp("R11 new value after edge", rdDataA, 32'h7777);
    // R8: first return from reset underflows
    phaseTag = "R8";
    mReset();
    doReset();
    step(0,1,0,0, 0,0,0, 0,0);
    step(0,0,0,0, 0,0,0, 0,0);
    cmp("R8 first return underflows", 32'(unfTrap), 32'h1);
    step(0,0,0,1, 0,0,0, 0,0);
    // R3: random traffic against the model
    phaseTag = "R3";
    for (int n = 0; n < 400; n++) begin
      int sel;
      bit c, r, sa, fa;
      sel = $urandom_range(0, 99);
      c = (sel < 25);
      r = (sel >= 25 && sel < 50);
      sa = ovfTrap ? ($urandom_range(0, 9) < 4) : ($urandom_range(0, 9) == 0);
      fa = unfTrap ? ($urandom_range(0, 9) < 4) : ($urandom_range(0, 9) == 0);
      step(c, r, sa, fa, bit'($urandom_range(0, 1)), $urandom_range(0, 31),
           $urandom, $urandom_range(0, 31), $urandom_range(0, 31));
    end
    step(0,0,0,0, 0,0,0, 0,0);
    finishRun();
  end
endmodule